// File: doc/BRIEF.md
# Slave Response Receiver with Busy Polling

This block takes over the serial data line once a command has left the master. On every cycle in which it is active it issues one bus clock and samples the line. It first hunts for the slave's start bit. It then decodes a 2-bit slave id and a 2-bit response code, collects any read data, and checks the 4-bit response CRC. Line levels are active low: a low line is a logical 1.

A busy answer starts a retry loop. The block drives a long idle preamble and sends a short poll command with its own small shifter. It gives echo clocks and then listens again. There is a limit on the number of retries. An error answer or a missing start bit leads to a fixed-length drain read before the error is reported. A good answer is followed by priming clocks so that the slave is ready for its next operation. Each transfer ends with a one-cycle `done` pulse, which carries an error code and, for reads, the right-aligned read data.

Top module: `slave_resp_rx`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `bclk_en`, `line_oe`, `busy` and `done` are low, `err_code` is 0 and `rd_data` is 0 until the first read completes.
- R2: While hunting, the block issues one bus clock per cycle with the line released. Logical bits are the inverse of `line_in`, and a start bit is `line_in` low. After TIMEOUT (1000) hunting cycles with no start bit, the block drains and reports error code 1.
- R3: After the start bit, 4 bits are received MSB first: the slave id (2 bits), then the response code (2 bits: 0 ACK, 1 BUSY, 2 any-error, 3 slave-seen CRC error). The id appears on `rsp_id`.
- R4: An ACK to a read with `xfer_len` bytes is followed by 8*`xfer_len` data bits, MSB first, which appear right-aligned in `rd_data` with the upper bits zero. An ACK to a write carries no data, and `rd_data` keeps its old value.
- R5: The expected CRC starts at 0. A logical 1 (the start bit) is folded in, then each id, code and data bit, using the rule c = (c<<1 mod 16) XOR (7 if bit XOR c[3] else 0). It is compared with the next 4 received bits, MSB first. A mismatch sets error code 5 but the transfer still completes normally, with read data presented.
- R6: After the CRC of an ACK, the block gives PRIME (100) bus clocks with the line released, then pulses `done`.
- R7: On BUSY, the block drives the line high (logical 0) for 100 cycles. It then drives a start bit and the 9-bit poll value 0x02A, MSB first, inverted on the line. It then drives the line high for 16 echo cycles and returns to hunting. All of these cycles are clocked.
- R8: When MAX_POLLS (100) polls have been sent and another BUSY arrives, `done` pulses on the next cycle with error code 2 and no drain.
- R9: On code 2 or 3, the block reads 20 more cycles with the line released, then reports error code 3 or 4.
- R10: `start` is ignored while `busy` is high, including any change of `rd_mode` and `xfer_len`.
- R11: `done` lasts one cycle and comes with `busy` low. The error codes are 0 ok, 1 timeout, 2 stuck-busy, 3 any-error, 4 slave CRC error, 5 bad response CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one bus clock per active cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the response phase (taken only when idle) |
| rd_mode | input | 1 | 1 = the command was a read |
| xfer_len | input | LEN_W | Transfer size in bytes |
| line_in | input | 1 | Sampled data line level (active low) |
| busy | output | 1 | Transfer in progress |
| bclk_en | output | 1 | Issue one bus clock this cycle |
| line_oe | output | 1 | Master drives the data line |
| line_out | output | 1 | Line level when driven |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 3 | Result code, valid with done |
| rsp_id | output | 2 | Slave id of the last decoded response |
| rd_data | output | DATA_W | Right-aligned read data |

## Verification
The line sampled in one cycle changes the state at the next edge. So the bench lists, for every active cycle, the expected clock, drive and level, together with the slave bit it puts on the line in that same cycle. It compares these at each falling edge. `done`, `err_code`, `rsp_id` and `rd_data` are due one cycle after the last listed step. They are checked there, and `done` is checked low one cycle later. Every phase length (hunt, data, CRC, preamble, poll, echo, drain, priming) is built into the list from the requirements. A phase that is one cycle too long or too short therefore misaligns the rest of the list.

// File: rtl/slave_resp_rx_pkg.sv
package slave_resp_rx_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_HUNT, S_HDR, S_DATA, S_CRC, S_PRIME, S_PRE, S_POLL, S_ECHO, S_DRAIN
  } rx_state_t;

  localparam logic [2:0] E_NONE    = 3'd0;
  localparam logic [2:0] E_TIMEOUT = 3'd1;
  localparam logic [2:0] E_STUCK   = 3'd2;
  localparam logic [2:0] E_ANY     = 3'd3;
  localparam logic [2:0] E_SLVCRC  = 3'd4;
  localparam logic [2:0] E_BADCRC  = 3'd5;

  localparam logic [1:0] RC_ACK  = 2'd0;
  localparam logic [1:0] RC_BUSY = 2'd1;
  localparam logic [1:0] RC_ANY  = 2'd2;
  localparam logic [1:0] RC_SCRC = 2'd3;

  function automatic logic [3:0] crc4_step(logic [3:0] c, logic b);
    logic m;
    m = b ^ c[3];
    return {c[2:0], 1'b0} ^ {1'b0, m, m, m};
  endfunction
endpackage

// File: rtl/rsp_tick_cnt.sv
module rsp_tick_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= q + CNT_W'(1);
  end
endmodule

// File: rtl/rsp_shift_in.sv
module rsp_shift_in
  import slave_resp_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] sh,
  output logic [3:0]        crc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      crc <= '0;
    end else if (clr) begin
      sh  <= '0;
      crc <= crc4_step(4'h0, 1'b1);
    end else if (en) begin
      sh  <= {sh[DATA_W-2:0], bit_in};
      crc <= crc4_step(crc, bit_in);
    end
  end
endmodule

// File: rtl/rsp_poll_tx.sv
module rsp_poll_tx #(
  parameter int          POLL_W   = 9,
  parameter logic [POLL_W-1:0] POLL_CMD = 9'h02A
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic adv,
  output logic bit_out
);
  localparam int SR_W = POLL_W + 1;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= {1'b1, POLL_CMD};
    else if (adv)  sr <= {sr[SR_W-2:0], 1'b0};
  end

  assign bit_out = sr[SR_W-1];
endmodule

// File: rtl/slave_resp_rx.sv
module slave_resp_rx
  import slave_resp_rx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 3,
  parameter int TIMEOUT   = 1000,
  parameter int IDLE_PRE  = 100,
  parameter int ECHO      = 16,
  parameter int MAX_POLLS = 100,
  parameter int DRAIN     = 20,
  parameter int PRIME     = 100,
  parameter int POLL_W    = 9,
  parameter logic [POLL_W-1:0] POLL_CMD = 9'h02A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_mode,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              line_in,
  output logic              busy,
  output logic              bclk_en,
  output logic              line_oe,
  output logic              line_out,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [1:0]        rsp_id,
  output logic [DATA_W-1:0] rd_data
);
  localparam int M1    = (TIMEOUT > PRIME) ? TIMEOUT : PRIME;
  localparam int M2    = (IDLE_PRE > DRAIN) ? IDLE_PRE : DRAIN;
  localparam int M3    = (ECHO > DATA_W) ? ECHO : DATA_W;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int MALL  = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MALL + 1) + 1;
  localparam int PC_W  = $clog2(MAX_POLLS + 1);

  rx_state_t           st, st_nx;
  logic [CNT_W-1:0]    cnt;
  logic [PC_W-1:0]     polls;
  logic                rd_q;
  logic [LEN_W-1:0]    len_q;
  logic [2:0]          err_q, err_nx;
  logic                fin;
  logic [3:0]          crc_rx;
  logic [DATA_W-1:0]   sh;
  logic [3:0]          crc_acc;
  logic                pbit;
  logic                lb;
  logic                hdr_last, crc_last;
  logic [1:0]          code_now;
  logic [CNT_W-1:0]    nbits_m1;
  logic [DATA_W-1:0]   dmask;

  assign lb        = ~line_in;
  assign hdr_last  = (st == S_HDR) && (cnt == CNT_W'(3));
  assign crc_last  = (st == S_CRC) && (cnt == CNT_W'(3));
  assign code_now  = {sh[0], lb};
  assign nbits_m1  = CNT_W'({len_q, 3'b000}) - CNT_W'(1);
  assign dmask     = (DATA_W'(1) << {len_q, 3'b000}) - DATA_W'(1);

  rsp_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk), .rst (rst),
    .clr ((st_nx != st) || (st == S_IDLE)),
    .q   (cnt)
  );

  rsp_shift_in #(.DATA_W(DATA_W)) u_shin (
    .clk    (clk), .rst (rst),
    .clr    ((st == S_HUNT) && lb),
    .en     ((st == S_HDR) || (st == S_DATA)),
    .bit_in (lb),
    .sh     (sh),
    .crc    (crc_acc)
  );

  rsp_poll_tx #(.POLL_W(POLL_W), .POLL_CMD(POLL_CMD)) u_poll (
    .clk (clk), .rst (rst),
    .load (st == S_PRE),
    .adv  (st == S_POLL),
    .bit_out (pbit)
  );

  always_comb begin
    st_nx  = st;
    err_nx = err_q;
    fin    = 1'b0;
    unique case (st)
      S_IDLE: if (start) st_nx = S_HUNT;
      S_HUNT: begin
        if (lb) st_nx = S_HDR;
        else if (cnt == CNT_W'(TIMEOUT - 1)) begin
          st_nx  = S_DRAIN;
          err_nx = E_TIMEOUT;
        end
      end
      S_HDR: if (hdr_last) begin
        unique case (code_now)
          RC_ACK:  st_nx = (rd_q && len_q != '0) ? S_DATA : S_CRC;
          RC_BUSY: begin
            if (polls == PC_W'(MAX_POLLS)) begin
              st_nx  = S_IDLE;
              fin    = 1'b1;
              err_nx = E_STUCK;
            end else st_nx = S_PRE;
          end
          RC_ANY:  begin st_nx = S_DRAIN; err_nx = E_ANY;    end
          default: begin st_nx = S_DRAIN; err_nx = E_SLVCRC; end
        endcase
      end
      S_DATA:  if (cnt == nbits_m1) st_nx = S_CRC;
      S_CRC:   if (crc_last) begin
        st_nx = S_PRIME;
        if ({crc_rx[2:0], lb} != crc_acc) err_nx = E_BADCRC;
      end
      S_PRIME: if (cnt == CNT_W'(PRIME - 1)) begin st_nx = S_IDLE; fin = 1'b1; end
      S_PRE:   if (cnt == CNT_W'(IDLE_PRE - 1)) st_nx = S_POLL;
      S_POLL:  if (cnt == CNT_W'(POLL_W)) st_nx = S_ECHO;
      S_ECHO:  if (cnt == CNT_W'(ECHO - 1)) st_nx = S_HUNT;
      S_DRAIN: if (cnt == CNT_W'(DRAIN - 1)) begin st_nx = S_IDLE; fin = 1'b1; end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      polls    <= '0;
      rd_q     <= 1'b0;
      len_q    <= '0;
      err_q    <= E_NONE;
      crc_rx   <= '0;
      done     <= 1'b0;
      err_code <= E_NONE;
      rsp_id   <= '0;
      rd_data  <= '0;
    end else begin
      st    <= st_nx;
      done  <= fin;
      err_q <= (st == S_IDLE) ? E_NONE : err_nx;
      if (st == S_IDLE && start) begin
        rd_q  <= rd_mode;
        len_q <= xfer_len;
        polls <= '0;
      end
      if (st == S_HDR && st_nx == S_PRE) polls <= polls + PC_W'(1);
      if (st == S_CRC) crc_rx <= {crc_rx[2:0], lb};
      if (hdr_last) rsp_id <= sh[2:1];
      if (crc_last && rd_q && len_q != '0) rd_data <= sh & dmask;
      if (fin) err_code <= err_nx;
    end
  end

  assign busy     = (st != S_IDLE);
  assign bclk_en  = (st != S_IDLE);
  assign line_oe  = (st == S_PRE) || (st == S_POLL) || (st == S_ECHO);
  assign line_out = (st == S_POLL) ? ~pbit : 1'b1;
endmodule

// File: rtl/slave_resp_rx_chk.sv
module slave_resp_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       bclk_en,
  input logic       line_oe,
  input logic       done,
  input logic [2:0] err_code
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R11
  err_range_chk: assert property (@(posedge clk) disable iff (rst) done |-> (err_code <= 3'd5));
  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));
  // R7
  drive_clocked_chk: assert property (@(posedge clk) disable iff (rst) line_oe |-> bclk_en);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (!bclk_en && !line_oe));
endmodule

bind slave_resp_rx slave_resp_rx_chk u_chk (
  .clk (clk), .rst (rst), .start (start), .busy (busy),
  .bclk_en (bclk_en), .line_oe (line_oe), .done (done), .err_code (err_code)
);

// File: tb/test_slave_resp_rx.sv
module test_slave_resp_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT = 1000;
  localparam int MAX_POLLS = 100;
  localparam int DRAIN = 20;
  localparam int PRIME = 100;

  typedef struct {
    bit oe; bit out; bit ck; bit line; string tag;
  } step_t;

  logic clk = 0, rst = 1, start = 0, rd_mode = 0, line_in = 1;
  logic [2:0] xfer_len = '0;
  logic busy, bclk_en, line_oe, line_out, done;
  logic [2:0] err_code;
  logic [1:0] rsp_id;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  step_t q[$];

  slave_resp_rx i_slave_resp_rx (
    .clk(clk), .rst(rst), .start(start), .rd_mode(rd_mode), .xfer_len(xfer_len),
    .line_in(line_in), .busy(busy), .bclk_en(bclk_en), .line_oe(line_oe),
    .line_out(line_out), .done(done), .err_code(err_code), .rsp_id(rsp_id),
    .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int fold(int c, bit b);
    int m;
    m = b ^ c[3];
    return ((c << 1) & 15) ^ (m ? 7 : 0);
  endfunction

  task automatic add(bit oe, bit out, bit ck, bit line, string tag);
    step_t s;
    s.oe = oe; s.out = out; s.ck = ck; s.line = line; s.tag = tag;
    q.push_back(s);
  endtask

  task automatic rx(bit b, string tag);
    add(0, 1, 1, ~b, tag);
  endtask

  task automatic hunt_idle(int n);
    for (int i = 0; i < n; i++) add(0, 1, 1, 1, "R2");
  endtask

  task automatic header(bit [1:0] id, bit [1:0] code);
    rx(1, "R2");
    rx(id[1], "R3"); rx(id[0], "R3"); rx(code[1], "R3"); rx(code[0], "R3");
  endtask

  task automatic ack(bit [1:0] id, int nbits, bit [31:0] data, bit corrupt);
    int c;
    header(id, 2'd0);
    c = fold(0, 1);
    c = fold(c, id[1]); c = fold(c, id[0]); c = fold(c, 0); c = fold(c, 0);
    for (int i = nbits - 1; i >= 0; i--) begin
      rx(data[i], "R4");
      c = fold(c, data[i]);
    end
    if (corrupt) c = c ^ 1;
    for (int i = 3; i >= 0; i--) rx(c[i], "R5");
    for (int i = 0; i < PRIME; i++) rx(0, "R6");
  endtask

  task automatic busy_poll();
    bit [9:0] v;
    v = {1'b1, 9'h02A};
    for (int i = 0; i < 100; i++) add(1, 1, 1, 1, "R7");
    for (int i = 9; i >= 0; i--) add(1, ~v[i], 1, 1, "R7");
    for (int i = 0; i < 16; i++) add(1, 1, 1, 1, "R7");
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < DRAIN; i++) add(0, 1, 1, 1, tag);
  endtask

  task automatic run(bit rd, int len, int poke, logic [2:0] eerr,
                     bit chk_rd, logic [31:0] erd, bit chk_id, logic [1:0] eid);
    @(negedge clk);
    start = 1; rd_mode = rd; xfer_len = 3'(len);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      start = (i == poke);
      if (i == poke) begin rd_mode = ~rd; xfer_len = 3'd1; end
      line_in = q[i].line;
      chk({bclk_en, line_oe, line_oe & line_out, busy, done} ==
          {q[i].ck, q[i].oe, q[i].oe & q[i].out, 1'b1, 1'b0},
          q[i].tag, $sformatf("step %0d pins", i),
          {bclk_en, line_oe, line_oe & line_out, busy, done},
          {q[i].ck, q[i].oe, q[i].oe & q[i].out, 1'b1, 1'b0});
    end
    @(negedge clk);
    start = 0; line_in = 1;
    chk(done && !busy, "R11", "done pulse", {done, busy}, 2'b10);
    chk(err_code == eerr, "R11", "err_code", err_code, eerr);
    if (chk_rd) chk(rd_data == erd, "R4", "rd_data", rd_data, erd);
    if (chk_id) chk(rsp_id == eid, "R3", "rsp_id", rsp_id, eid);
    @(negedge clk);
    chk(!done && !bclk_en && !line_oe, "R11", "done single cycle, idle quiet",
        {done, bclk_en, line_oe}, 0);
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({busy, bclk_en, line_oe, done} == 0, "R1", "idle pins", {busy, bclk_en, line_oe, done}, 0);
    chk(err_code == 0 && rd_data == 0, "R1", "reset results", rd_data, 0);
    // start ignored idle: nothing moves without start (R1)
    repeat (3) @(negedge clk);
    chk(!bclk_en, "R1", "no clocks while idle", bclk_en, 0);

    // R4 write ACK, no data, rd_data unchanged
    hunt_idle(0); ack(2'd1, 0, 0, 0);
    run(0, 4, -1, 3'd0, 1, 32'h0, 1, 2'd1);

    // R4 read 4 bytes
    hunt_idle(7); ack(2'd2, 32, 32'hA5C30F96, 0);
    run(1, 4, -1, 3'd0, 1, 32'hA5C30F96, 1, 2'd2);

    // R4 read 1 byte right-aligned
    hunt_idle(3); ack(2'd3, 8, 32'h3C, 0);
    run(1, 1, -1, 3'd0, 1, 32'h3C, 1, 2'd3);

    // R5 read 2 bytes with bad CRC: err 5, data still given
    hunt_idle(1); ack(2'd0, 16, 32'hBEEF, 1);
    run(1, 2, -1, 3'd5, 1, 32'hBEEF, 1, 2'd0);

    // R7 two busy answers then write ACK; R10 start poked mid-transfer
    hunt_idle(2); header(2'd1, 2'd1); busy_poll();
    hunt_idle(4); header(2'd1, 2'd1); busy_poll();
    hunt_idle(0); ack(2'd1, 0, 0, 0);
    run(0, 2, 50, 3'd0, 1, 32'hBEEF, 1, 2'd1);

    // R9 any-error
    hunt_idle(5); header(2'd2, 2'd2); drain("R9");
    run(1, 4, 3, 3'd3, 1, 32'hBEEF, 1, 2'd2);

    // R9 slave-seen CRC error
    hunt_idle(0); header(2'd3, 2'd3); drain("R9");
    run(0, 1, -1, 3'd4, 0, 0, 1, 2'd3);

    // R2 timeout
    hunt_idle(TIMEOUT); drain("R2");
    run(1, 4, -1, 3'd1, 1, 32'hBEEF, 0, 0);

    // R8 stuck busy
    for (int k = 0; k < MAX_POLLS; k++) begin
      hunt_idle(1); header(2'd2, 2'd1); busy_poll();
    end
    hunt_idle(1); header(2'd2, 2'd1);
    run(1, 4, -1, 3'd2, 1, 32'hBEEF, 1, 2'd2);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule